// File: doc/BRIEF.md
# PTP Path Delay, Offset and Drift Calculator

This block turns the four event timestamps of one master-slave timing exchange into the two figures a slave clock needs: the mean one-way path delay and the offset of the slave clock from the master clock. The timestamps are signed 64-bit nanosecond values. The first two mark the forward event: the master sends, then the slave receives. The last two mark the reverse event: the slave sends, then the master receives. All four are presented together, qualified by a single strobe. The offset takes the slave-minus-master sign convention. A positive offset means the slave clock is ahead.

The block also keeps the forward send/receive pair of the previous accepted exchange. From that pair and the current one it forms a drift term. The drift term is the growth of the slave receive interval minus the growth of the master send interval between the two exchanges. A synchronous clear input discards that history so that drift measurement restarts. All results are registered and carry their own valid pulses. Outputs keep their last value between pulses.

Top module: `ptp_offset_calc`

## Requirements
- R1: While `rst_n` is low at a clock edge, every result output goes to zero and every valid output goes low.
- R2: With forward difference A = t1 - t0 and reverse difference B = t3 - t2, both computed exactly, `delay` equals floor((A + B) / 2). The division is an arithmetic right shift, so it rounds toward minus infinity.
- R3: `offset` equals floor((A - B) / 2), with the sign of slave minus master. Negative values and odd differences round toward minus infinity.
- R4: When `ts_valid` is high at a clock edge, `delay`, `offset`, `delay_vld` and `offset_vld` update at that edge. The valid flags stay high for exactly one cycle.
- R5: No input values overflow. `delay` and `offset` are 65-bit signed and `drift` is 66-bit signed. This holds even when the timestamps reach the 64-bit signed extremes.
- R6: When drift history is held, an accepted exchange gives `drift` = (t1 - t1_prev) - (t0 - t0_prev). The `_prev` values come from the previous accepted exchange. `drift_vld` pulses in the same cycle as `delay_vld`.
- R7: The first accepted exchange after reset raises no `drift_vld` and leaves `drift` unchanged. It only loads the history.
- R8: A `hist_clr` pulse without `ts_valid` empties the history. The next accepted exchange then produces no drift and leaves `drift` unchanged.
- R9: When `hist_clr` and `ts_valid` are high in the same cycle, delay and offset are still produced, but no drift is produced. That exchange becomes the new history, so the following exchange yields drift against it.
- R10: With `ts_valid` low, the timestamp inputs are ignored. All results hold and no valid flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_valid | input | 1 | Qualifies t0..t3 as one complete exchange |
| hist_clr | input | 1 | Discards the stored drift history |
| t0 | input | 64 | Master send time of the forward event, signed ns |
| t1 | input | 64 | Slave receive time of the forward event, signed ns |
| t2 | input | 64 | Slave send time of the reverse event, signed ns |
| t3 | input | 64 | Master receive time of the reverse event, signed ns |
| delay | output | 65 | Mean path delay, signed ns |
| delay_vld | output | 1 | One-cycle pulse when delay updates |
| offset | output | 65 | Slave minus master offset, signed ns |
| offset_vld | output | 1 | One-cycle pulse when offset updates |
| drift | output | 66 | Interval growth difference, signed ns |
| drift_vld | output | 1 | One-cycle pulse when drift updates |

## Verification
The history clear and an exchange strobe can arrive in the same cycle. In that case the clear must win for the drift output, while the exchange must still load the new history. The bench provokes this case with a directed step and, at random, during the long random run. It judges the result at the ports: delay and offset appear, drift holds with no pulse, and the next exchange must yield drift measured against the cleared-cycle exchange. The bench model tracks history and clear independently of the RTL, so a wrong priority shows up as a missing or spurious drift pulse, or as a wrong drift value one exchange later.

// File: rtl/ptp_calc_pkg.sv
// Package: shared constants for the PTP delay/offset/drift calculator.
// Assumes timestamps are signed two's-complement nanosecond counts.
package ptp_calc_pkg;
    localparam int TS_W_DEFAULT = 64;   // timestamp width in bits
    localparam int GUARD_BITS   = 1;    // growth of one exact subtraction
endpackage

// File: rtl/ptp_path_diff.sv
// Module: forms the exact forward (t1 - t0) and reverse (t3 - t2)
// differences one bit wider than the timestamps. Purely combinational.
// Assumes signed timestamps of TS_W bits.
module ptp_path_diff
    import ptp_calc_pkg::*;
#(
    parameter int TS_W = TS_W_DEFAULT,
    localparam int DW  = TS_W + GUARD_BITS
) (
    input  logic signed [TS_W-1:0] t0_i,
    input  logic signed [TS_W-1:0] t1_i,
    input  logic signed [TS_W-1:0] t2_i,
    input  logic signed [TS_W-1:0] t3_i,
    output logic signed [DW-1:0]   fwd_o,
    output logic signed [DW-1:0]   rev_o
);
    // Sign-extend both operands so each difference is exact.
    always_comb begin
        fwd_o = DW'(t1_i) - DW'(t0_i);
        rev_o = DW'(t3_i) - DW'(t2_i);
    end
endmodule

// File: rtl/ptp_delay_offset.sv
// Module: registers delay = floor((A+B)/2) and offset = floor((A-B)/2).
// Halving is an arithmetic shift of the exact DW+1 bit sum/difference.
// Assumes A and B arrive exact (DW bits) and stable in the strobe cycle.
module ptp_delay_offset
    import ptp_calc_pkg::*;
#(
    parameter int TS_W = TS_W_DEFAULT,
    localparam int DW  = TS_W + GUARD_BITS,
    localparam int SW  = DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic signed [DW-1:0] fwd_i,
    input  logic signed [DW-1:0] rev_i,
    output logic signed [DW-1:0] delay_o,
    output logic signed [DW-1:0] offset_o,
    output logic                 vld_o
);
    logic signed [SW-1:0] sum_w;
    logic signed [SW-1:0] dif_w;

    // Exact sum and difference of the two path differences.
    always_comb begin
        sum_w = SW'(fwd_i) + SW'(rev_i);
        dif_w = SW'(fwd_i) - SW'(rev_i);
    end

    // Capture halved results on a strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_o  <= '0;
            offset_o <= '0;
            vld_o    <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                delay_o  <= sum_w[SW-1:1];
                offset_o <= dif_w[SW-1:1];
            end
        end
    end

    logic signed [SW-1:0] recomb_w;
    logic signed [SW-1:0] fwd_ext_w;
    localparam logic signed [SW-1:0] ONE = SW'(1);
    always_comb begin
        recomb_w  = SW'(delay_o) + SW'(offset_o);
        fwd_ext_w = SW'(fwd_i);
    end

    AST_RECOMBINE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (recomb_w == $past(fwd_ext_w)) || (recomb_w == $past(fwd_ext_w) - ONE)); // R2
    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !vld_o) |-> ($stable(delay_o) && $stable(offset_o))); // R10
endmodule

// File: rtl/ptp_drift_track.sv
// Module: keeps the previous accepted forward pair and registers
// drift = (t1 - t1_prev) - (t0 - t0_prev) from the second pair onward.
// A clear empties the history; a clear with a strobe reloads it without output.
// Assumes signed timestamps of TS_W bits.
module ptp_drift_track
    import ptp_calc_pkg::*;
#(
    parameter int TS_W = TS_W_DEFAULT,
    localparam int DW  = TS_W + GUARD_BITS,
    localparam int RW  = DW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vld_i,
    input  logic                   clr_i,
    input  logic signed [TS_W-1:0] t0_i,
    input  logic signed [TS_W-1:0] t1_i,
    output logic signed [RW-1:0]   drift_o,
    output logic                   vld_o
);
    logic signed [TS_W-1:0] prev_t0_q;
    logic signed [TS_W-1:0] prev_t1_q;
    logic                   hist_q;
    logic signed [DW-1:0]   d_mst_w;
    logic signed [DW-1:0]   d_slv_w;
    logic signed [RW-1:0]   drift_w;

    // Interval growth on each side, then their exact difference.
    always_comb begin
        d_mst_w = DW'(t0_i) - DW'(prev_t0_q);
        d_slv_w = DW'(t1_i) - DW'(prev_t1_q);
        drift_w = RW'(d_slv_w) - RW'(d_mst_w);
    end

    // History load/clear and drift capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_t0_q <= '0;
            prev_t1_q <= '0;
            hist_q    <= 1'b0;
            drift_o   <= '0;
            vld_o     <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            if (vld_i) begin
                if (hist_q && !clr_i) begin
                    drift_o <= drift_w;
                    vld_o   <= 1'b1;
                end
                prev_t0_q <= t0_i;
                prev_t1_q <= t1_i;
                hist_q    <= 1'b1;
            end else if (clr_i) begin
                hist_q <= 1'b0;
            end
        end
    end

    AST_NO_DRIFT_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr_i)) |-> !vld_o); // R8
    AST_FIRST_PAIR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !hist_q) |=> !vld_o); // R7
    AST_DRIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !vld_o) |-> $stable(drift_o)); // R10
endmodule

// File: rtl/ptp_offset_calc.sv
// Module: top of the PTP calculator. Derives path differences, then
// registers delay/offset and the inter-exchange drift in parallel.
// Assumes all four timestamps of one exchange are valid in the strobe cycle.
module ptp_offset_calc
    import ptp_calc_pkg::*;
#(
    parameter int TS_W = TS_W_DEFAULT,
    localparam int DW  = TS_W + GUARD_BITS,
    localparam int RW  = DW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ts_valid,
    input  logic                   hist_clr,
    input  logic signed [TS_W-1:0] t0,
    input  logic signed [TS_W-1:0] t1,
    input  logic signed [TS_W-1:0] t2,
    input  logic signed [TS_W-1:0] t3,
    output logic signed [DW-1:0]   delay,
    output logic                   delay_vld,
    output logic signed [DW-1:0]   offset,
    output logic                   offset_vld,
    output logic signed [RW-1:0]   drift,
    output logic                   drift_vld
);
    logic signed [DW-1:0] fwd_w;
    logic signed [DW-1:0] rev_w;
    logic                 do_vld_w;

    ptp_path_diff #(.TS_W(TS_W)) u_diff (
        .t0_i(t0), .t1_i(t1), .t2_i(t2), .t3_i(t3),
        .fwd_o(fwd_w), .rev_o(rev_w)
    );

    ptp_delay_offset #(.TS_W(TS_W)) u_dlyoff (
        .clk(clk), .rst_n(rst_n), .vld_i(ts_valid),
        .fwd_i(fwd_w), .rev_i(rev_w),
        .delay_o(delay), .offset_o(offset), .vld_o(do_vld_w)
    );

    ptp_drift_track #(.TS_W(TS_W)) u_drift (
        .clk(clk), .rst_n(rst_n), .vld_i(ts_valid), .clr_i(hist_clr),
        .t0_i(t0), .t1_i(t1), .drift_o(drift), .vld_o(drift_vld)
    );

    // Both path results share one strobe.
    always_comb begin
        delay_vld  = do_vld_w;
        offset_vld = do_vld_w;
    end

    AST_DRIFT_WITH_EXCH: assert property (@(posedge clk) disable iff (!rst_n)
        drift_vld |-> delay_vld); // R6
    AST_VLD_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (delay_vld == $past(ts_valid))); // R4
endmodule

// File: tb/tb_ptp_offset_calc.sv
module tb_ptp_offset_calc;
    localparam int  TS_W   = 64;
    localparam time CLK_PS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ts_valid = 1'b0;
    logic hist_clr = 1'b0;
    logic signed [TS_W-1:0] t0 = '0, t1 = '0, t2 = '0, t3 = '0;
    logic signed [TS_W:0]   delay, offset;
    logic signed [TS_W+1:0] drift;
    logic delay_vld, offset_vld, drift_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state.
    logic signed [TS_W-1:0] m_p0 = '0, m_p1 = '0;
    bit m_hist = 1'b0;
    logic signed [TS_W+1:0] m_drift = '0, m_delay = '0, m_offset = '0;

    always #(CLK_PS/2) clk = ~clk;

    ptp_offset_calc #(.TS_W(TS_W)) dut (
        .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .hist_clr(hist_clr),
        .t0(t0), .t1(t1), .t2(t2), .t3(t3),
        .delay(delay), .delay_vld(delay_vld), .offset(offset),
        .offset_vld(offset_vld), .drift(drift), .drift_vld(drift_vld)
    );

    function automatic logic signed [TS_W+1:0] ext(input logic signed [TS_W-1:0] v);
        return (TS_W+2)'(v);
    endfunction

    function automatic logic signed [TS_W+1:0] half(input logic signed [TS_W+1:0] v);
        return v >>> 1;
    endfunction

    function automatic logic signed [TS_W-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic chk(input string req, input logic signed [TS_W+1:0] act,
                       input logic signed [TS_W+1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one exchange; sample on the following falling edge.
    task automatic exch(input logic signed [TS_W-1:0] a0, a1, a2, a3, input bit clr);
        logic signed [TS_W+1:0] fa, rb;
        @(negedge clk);
        t0 = a0; t1 = a1; t2 = a2; t3 = a3;
        ts_valid = 1'b1; hist_clr = clr;
        fa = ext(a1) - ext(a0);
        rb = ext(a3) - ext(a2);
        m_delay  = half(fa + rb);
        m_offset = half(fa - rb);
        @(negedge clk);
        ts_valid = 1'b0; hist_clr = 1'b0;
        chk("R2 delay", (TS_W+2)'(delay), m_delay);
        chk("R3 offset", (TS_W+2)'(offset), m_offset);
        chk("R4 delay_vld", (TS_W+2)'(delay_vld), 1);
        chk("R4 offset_vld", (TS_W+2)'(offset_vld), 1);
        if (m_hist && !clr) begin
            m_drift = (ext(a1) - ext(m_p1)) - (ext(a0) - ext(m_p0));
            chk("R6 drift_vld", (TS_W+2)'(drift_vld), 1);
        end else begin
            chk(clr ? "R9 drift_vld" : "R7 drift_vld", (TS_W+2)'(drift_vld), 0);
        end
        chk("R6 drift", drift, m_drift);
        m_p0 = a0; m_p1 = a1; m_hist = 1'b1;
        @(negedge clk);
        chk("R4 vld single cycle", (TS_W+2)'(delay_vld | offset_vld | drift_vld), 0);
    endtask

    // Clear without a strobe.
    task automatic clr_only();
        @(negedge clk);
        hist_clr = 1'b1;
        @(negedge clk);
        hist_clr = 1'b0;
        m_hist = 1'b0;
    endtask

    // Random inputs with strobe low must change nothing.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            t0 = rnd64(); t1 = rnd64(); t2 = rnd64(); t3 = rnd64();
            @(negedge clk);
            chk("R10 delay hold", (TS_W+2)'(delay), m_delay);
            chk("R10 offset hold", (TS_W+2)'(offset), m_offset);
            chk("R10 drift hold", drift, m_drift);
            chk("R10 no valid", (TS_W+2)'(delay_vld | offset_vld | drift_vld), 0);
        end
    endtask

    initial begin
        #(CLK_PS * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R4 run stalled");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic signed [TS_W-1:0] mn, mx, base;
        void'($urandom(32'd20240607));
        mn = {1'b1, {(TS_W-1){1'b0}}};
        mx = {1'b0, {(TS_W-1){1'b1}}};
        repeat (3) @(negedge clk);
        chk("R1 delay", (TS_W+2)'(delay), 0);
        chk("R1 offset", (TS_W+2)'(offset), 0);
        chk("R1 drift", drift, 0);
        chk("R1 valids", (TS_W+2)'(delay_vld | offset_vld | drift_vld), 0);
        rst_n = 1'b1;

        // R7 first pair, then R6 drift.
        exch(64'sd1000, 64'sd1530, 64'sd2000, 64'sd2470, 1'b0);
        exch(64'sd3000, 64'sd3545, 64'sd4000, 64'sd4470, 1'b0);
        // R3 negative, odd difference.
        exch(64'sd5000, 64'sd5001, 64'sd6000, 64'sd6110, 1'b0);
        idle(3);
        // R8 clear alone.
        clr_only();
        exch(64'sd7000, 64'sd7600, 64'sd8000, 64'sd8400, 1'b0);
        exch(64'sd9000, 64'sd9590, 64'sd9900, 64'sd9990, 1'b0);
        // R9 clear with strobe, next exchange drifts against it.
        exch(64'sd11000, 64'sd11700, 64'sd12000, 64'sd12300, 1'b1);
        exch(64'sd13000, 64'sd13720, 64'sd14000, 64'sd14290, 1'b0);
        // R5 extremes.
        exch(mn, mx, mx, mn, 1'b0);
        exch(mx, mn, mn, mx, 1'b0);
        exch(-64'sd7, -64'sd2, 64'sd0, -64'sd3, 1'b0);
        idle(2);

        // Random run: near-consistent timestamps plus full-range vectors.
        for (int i = 0; i < 300; i++) begin
            if (i % 5 == 4) begin
                exch(rnd64(), rnd64(), rnd64(), rnd64(), ($urandom() % 4) == 0);
            end else begin
                base = rnd64() >>> 2;
                exch(base, base + TS_W'($urandom() % 4096) - 64'sd2048,
                     base + 64'sd100000, base + 64'sd100000 + TS_W'($urandom() % 4096),
                     ($urandom() % 8) == 0);
            end
            if (($urandom() % 10) == 0) clr_only();
            if (($urandom() % 10) == 0) idle(1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule